// File: doc/BRIEF.md
# CAN Receive FIFO with Interrupt-Clear Service Handshake

This block is a small frame queue for a CAN controller. It sits ahead of the regular mailboxes. The matching engine writes accepted frames into it with a single-cycle move-in strobe. Each frame carries a control/status word, an identifier and 64 bits of payload. The CPU always sees the oldest stored frame on three output words. Reading those words has no side effect. The CPU releases the frame by clearing the frames-available interrupt, and that clear is the only event that advances the read side.

The block also holds an eight-entry acceptance identifier table. The matching engine reads it to decide whether a frame goes to the queue or on to the mailboxes. A full indication tells the engine to skip the queue and match against the mailboxes only. The queue enable and the table can be changed only while the controller is frozen. Disabling the queue flushes it.

Top module: `rxf_svc`

## Requirements
- R1: After reset the queue is disabled and empty. `fifo_en_o`, `full_o`, `warn_o`, `ovf_o` and `frm_avail_o` are 0, every identifier table entry is 0, and all head words are 0.
- R2: The enable write (`cfg_en_we_i`) and the table write (`id_we_i`) take effect at a clock edge only when `freeze_i` is high. At any other time they leave `fifo_en_o` and `id_table_o` unchanged. Table entry k appears on `id_table_o[32k+31:32k]`.
- R3: A move-in while the queue is enabled and not full stores the frame. The head words show the oldest stored frame in arrival order and hold it unchanged until it is released.
- R4: `frm_avail_o` rises one cycle after the clock edge at which the queue goes from empty to non-empty. It stays high while frames remain and no clear is taken.
- R5: `irq_clr_i` sampled high while `frm_avail_o` is high releases the head frame. `frm_avail_o` is then low for exactly one cycle and rises again in the following cycle if frames remain. `irq_clr_i` while `frm_avail_o` is low is ignored.
- R6: `full_o` is high exactly when six frames are stored. A move-in that arrives while `full_o` is high is discarded, and the stored frames are unchanged.
- R7: A discarded move-in sets `ovf_o`. `ovf_o` stays set until the queue is disabled.
- R8: `warn_o` is high exactly while five or more frames are stored.
- R9: Writing enable = 0 during freeze empties the queue and clears `ovf_o` and `frm_avail_o`. Move-ins while the queue is disabled are ignored.
- R10: A move-in and a taken clear in the same cycle both take effect. If the queue was full, `full_o` is judged before the release, so the new frame is discarded and `ovf_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Controller freeze mode, unlocks configuration |
| cfg_en_we_i | input | 1 | Write strobe for the queue enable |
| cfg_en_i | input | 1 | Enable value to write |
| id_we_i | input | 1 | Write strobe for an identifier table entry |
| id_idx_i | input | 3 | Table entry index |
| id_wdata_i | input | 32 | Table entry value |
| fifo_en_o | output | 1 | Queue enabled |
| id_table_o | output | 256 | All table entries, entry k at bits 32k+31:32k |
| mv_valid_i | input | 1 | Move-in strobe from the matching engine |
| mv_cs_i | input | 32 | Move-in control/status word |
| mv_id_i | input | 32 | Move-in identifier |
| mv_data_i | input | 64 | Move-in payload |
| full_o | output | 1 | Six frames stored; route matching to mailboxes |
| warn_o | output | 1 | Five or more frames stored |
| ovf_o | output | 1 | Sticky: a move-in was discarded |
| frm_avail_o | output | 1 | Frames-available interrupt |
| irq_clr_i | input | 1 | CPU clears the interrupt, releasing the head |
| head_cs_o | output | 32 | Oldest frame control/status word |
| head_id_o | output | 32 | Oldest frame identifier |
| head_data_o | output | 64 | Oldest frame payload |

## Verification
A move-in from the matching engine and an interrupt clear from the CPU can land in the same cycle. The bench provokes this twice. The first time the queue holds two frames: the clear must expose the second frame and the new frame must follow it, so the occupancy stays the same. The second time the queue is full: the clear must release the head while the move-in is dropped with `ovf_o` set. This is judged by draining the queue and checking that the dropped frame never appears on the head words.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int unsigned CS_W   = 32;
  parameter int unsigned ID_W   = 32;
  parameter int unsigned DATA_W = 64;

  typedef struct packed {
    logic [CS_W-1:0]   cs;
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } rxf_frame_t;
endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg import rxf_pkg::*; #(
  parameter int unsigned ID_ENTRIES = 8,
  parameter int unsigned IDX_W      = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       freeze_i,
  input  logic                       en_we_i,
  input  logic                       en_i,
  input  logic                       id_we_i,
  input  logic [IDX_W-1:0]           id_idx_i,
  input  logic [ID_W-1:0]            id_wdata_i,
  output logic                       en_o,
  output logic                       flush_o,
  output logic [ID_ENTRIES*ID_W-1:0] table_o
);
  logic en_q;

  // a disable request during freeze empties the queue
  assign flush_o = freeze_i & en_we_i & ~en_i;
  assign en_o    = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  en_q <= 1'b0;
    else if (freeze_i && en_we_i) en_q <= en_i;
  end

  for (genvar g = 0; g < ID_ENTRIES; g++) begin : g_tbl
    logic [ID_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (freeze_i && id_we_i && (id_idx_i == IDX_W'(g))) ent_q <= id_wdata_i;
    end
    assign table_o[g*ID_W +: ID_W] = ent_q;
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store import rxf_pkg::*; #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  rxf_frame_t       frame_i,
  output rxf_frame_t       head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  rxf_frame_t       slot [DEPTH];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot[g] <= '0;
      else if (push_i && (wr_q == PTR_W'(g)))   slot[g] <= frame_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = slot[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int unsigned WARN_LVL = 5,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             full_i,
  input  logic             mv_valid_i,
  input  logic             clr_i,
  output logic             pop_o,
  output logic             avail_o,
  output logic             warn_o,
  output logic             ovf_o
);
  logic avail_q, ovf_q;

  // a clear counts only while the interrupt is visible
  assign pop_o = clr_i & avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      // one-cycle gap after a taken clear, then re-arm from occupancy
      avail_q <= en_i & ~flush_i & ~pop_o & (count_i != '0);
      if (flush_i)                           ovf_q <= 1'b0;
      else if (en_i && mv_valid_i && full_i) ovf_q <= 1'b1;
    end
  end

  assign avail_o = avail_q;
  assign ovf_o   = ovf_q;
  assign warn_o  = (count_i >= CNT_W'(WARN_LVL));
endmodule

// File: rtl/rxf_svc.sv
module rxf_svc import rxf_pkg::*; #(
  parameter int unsigned DEPTH      = 6,
  parameter int unsigned WARN_LVL   = 5,
  parameter int unsigned ID_ENTRIES = 8,
  localparam int unsigned IDX_W     = (ID_ENTRIES > 1) ? $clog2(ID_ENTRIES) : 1,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       freeze_i,
  input  logic                       cfg_en_we_i,
  input  logic                       cfg_en_i,
  input  logic                       id_we_i,
  input  logic [IDX_W-1:0]           id_idx_i,
  input  logic [ID_W-1:0]            id_wdata_i,
  output logic                       fifo_en_o,
  output logic [ID_ENTRIES*ID_W-1:0] id_table_o,
  input  logic                       mv_valid_i,
  input  logic [CS_W-1:0]            mv_cs_i,
  input  logic [ID_W-1:0]            mv_id_i,
  input  logic [DATA_W-1:0]          mv_data_i,
  output logic                       full_o,
  output logic                       warn_o,
  output logic                       ovf_o,
  output logic                       frm_avail_o,
  input  logic                       irq_clr_i,
  output logic [CS_W-1:0]            head_cs_o,
  output logic [ID_W-1:0]            head_id_o,
  output logic [DATA_W-1:0]          head_data_o
);
  logic             en, flush, push, pop;
  logic [CNT_W-1:0] count;
  rxf_frame_t       in_frame, head;

  rxf_cfg #(.ID_ENTRIES(ID_ENTRIES), .IDX_W(IDX_W)) i_cfg (
    .clk_i, .rst_ni, .freeze_i,
    .en_we_i   (cfg_en_we_i),
    .en_i      (cfg_en_i),
    .id_we_i, .id_idx_i, .id_wdata_i,
    .en_o      (en),
    .flush_o   (flush),
    .table_o   (id_table_o)
  );

  assign full_o   = (count == CNT_W'(DEPTH));
  assign push     = mv_valid_i & en & ~full_o;
  assign in_frame = '{cs: mv_cs_i, id: mv_id_i, data: mv_data_i};

  rxf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_store (
    .clk_i, .rst_ni,
    .push_i  (push),
    .pop_i   (pop),
    .flush_i (flush),
    .frame_i (in_frame),
    .head_o  (head),
    .count_o (count)
  );

  rxf_flags #(.WARN_LVL(WARN_LVL), .CNT_W(CNT_W)) i_flags (
    .clk_i, .rst_ni,
    .en_i       (en),
    .flush_i    (flush),
    .count_i    (count),
    .full_i     (full_o),
    .mv_valid_i,
    .clr_i      (irq_clr_i),
    .pop_o      (pop),
    .avail_o    (frm_avail_o),
    .warn_o,
    .ovf_o
  );

  assign fifo_en_o   = en;
  assign head_cs_o   = head.cs;
  assign head_id_o   = head.id;
  assign head_data_o = head.data;
endmodule

// File: rtl/rxf_svc_chk.sv
module rxf_svc_chk #(
  parameter int unsigned ID_ENTRIES = 8,
  parameter int unsigned ID_W       = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       freeze_i,
  input logic                       cfg_en_we_i,
  input logic                       cfg_en_i,
  input logic                       fifo_en_o,
  input logic [ID_ENTRIES*ID_W-1:0] id_table_o,
  input logic                       mv_valid_i,
  input logic                       full_o,
  input logic                       warn_o,
  input logic                       ovf_o,
  input logic                       frm_avail_o,
  input logic                       irq_clr_i
);
  logic dis_req;
  assign dis_req = freeze_i & cfg_en_we_i & ~cfg_en_i;

  assert_cfg_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i |=> ($stable(fifo_en_o) && $stable(id_table_o)));

  assert_clr_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_avail_o && irq_clr_i) |=> !frm_avail_o);

  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && mv_valid_i && !dis_req) |=> ovf_o);

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !dis_req) |=> ovf_o);

  assert_warn_at_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> warn_o);

  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_o |-> (!frm_avail_o && !full_o));
endmodule

bind rxf_svc rxf_svc_chk #(.ID_ENTRIES(ID_ENTRIES), .ID_W(rxf_pkg::ID_W)) i_chk (.*);

// File: tb/test_rxf_svc.sv
module test_rxf_svc;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         freeze = 0, cfg_en_we = 0, cfg_en = 0, id_we = 0;
  logic [2:0]   id_idx = '0;
  logic [31:0]  id_wdata = '0;
  logic         fifo_en;
  logic [255:0] id_table;
  logic         mv_valid = 0;
  logic [31:0]  mv_cs = '0, mv_id = '0;
  logic [63:0]  mv_data = '0;
  logic         full, warn, ovf, avail, irq_clr = 0;
  logic [31:0]  h_cs, h_id;
  logic [63:0]  h_data;
  int           n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rxf_svc i_rxf_svc (
    .clk_i(clk), .rst_ni(rst_n), .freeze_i(freeze),
    .cfg_en_we_i(cfg_en_we), .cfg_en_i(cfg_en),
    .id_we_i(id_we), .id_idx_i(id_idx), .id_wdata_i(id_wdata),
    .fifo_en_o(fifo_en), .id_table_o(id_table),
    .mv_valid_i(mv_valid), .mv_cs_i(mv_cs), .mv_id_i(mv_id), .mv_data_i(mv_data),
    .full_o(full), .warn_o(warn), .ovf_o(ovf), .frm_avail_o(avail),
    .irq_clr_i(irq_clr),
    .head_cs_o(h_cs), .head_id_o(h_id), .head_data_o(h_data)
  );

  function automatic logic [127:0] frm(input int n);
    return {32'hC500_0000 | 32'(n), 32'h1800_0000 + 32'(n), 32'hDA7A_0000 | 32'(n), ~32'(n)};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_head(input string req, input int n);
    chk({h_cs, h_id, h_data} == frm(n), req, {h_cs, h_id, h_data}, frm(n));
  endtask

  task automatic put_frame(input int n);
    {mv_cs, mv_id, mv_data} = frm(n);
  endtask

  task automatic mv(input int n);
    put_frame(n);
    mv_valid = 1;
    step();
    mv_valid = 0;
  endtask

  task automatic clr();
    irq_clr = 1;
    step();
    irq_clr = 0;
  endtask

  task automatic set_en(input bit v);
    freeze = 1; cfg_en_we = 1; cfg_en = v;
    step();
    cfg_en_we = 0; freeze = 0;
  endtask

  task automatic t_reset();
    chk(!fifo_en && !full && !warn && !ovf && !avail, "R1 flags", {fifo_en, full, warn, ovf, avail}, 0);
    chk(id_table == '0, "R1 table", id_table[127:0], 0);
    chk({h_cs, h_id, h_data} == '0, "R1 head", {h_cs, h_id, h_data}, 0);
  endtask

  task automatic t_cfg();
    freeze = 0; cfg_en_we = 1; cfg_en = 1; id_we = 1; id_idx = 3; id_wdata = 32'hABCD_1234;
    step();
    cfg_en_we = 0; id_we = 0;
    chk(!fifo_en, "R2 enable ignored outside freeze", fifo_en, 0);
    chk(id_table[3*32 +: 32] == '0, "R2 table ignored outside freeze", id_table[3*32 +: 32], 0);
    freeze = 1;
    for (int k = 0; k < 8; k++) begin
      id_we = 1; id_idx = 3'(k); id_wdata = 32'h0700_0000 + 32'(k);
      step();
    end
    id_we = 0; cfg_en_we = 1; cfg_en = 1;
    step();
    cfg_en_we = 0; freeze = 0;
    chk(fifo_en, "R2 enable in freeze", fifo_en, 1);
    chk(id_table[5*32 +: 32] == 32'h0700_0005, "R2 table entry 5", id_table[5*32 +: 32], 32'h0700_0005);
    chk(id_table[0 +: 32] == 32'h0700_0000, "R2 table entry 0", id_table[0 +: 32], 32'h0700_0000);
  endtask

  task automatic t_single();
    mv(1);
    chk(!avail, "R4 interrupt lags one cycle", avail, 0);
    chk_head("R3 head after move-in", 1);
    step();
    chk(avail, "R4 interrupt raised", avail, 1);
    repeat (3) step();
    chk(avail, "R4 interrupt held", avail, 1);
    chk_head("R3 head stable", 1);
    clr();
    chk(!avail, "R5 gap after clear", avail, 0);
    step();
    chk(!avail, "R5 stays low when empty", avail, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 6; i++) begin
      mv(10 + i);
      chk(warn == ((i + 1) >= 5), "R8 warn level", warn, (i + 1) >= 5);
      chk(full == ((i + 1) == 6), "R6 full level", full, (i + 1) == 6);
    end
    chk(!ovf, "R7 no overflow yet", ovf, 0);
    mv(99);
    chk(ovf, "R7 overflow set", ovf, 1);
    chk(full, "R6 still full", full, 1);
    for (int k = 0; k < 6; k++) begin
      chk(avail, "R5 interrupt re-armed", avail, 1);
      chk_head("R6 order kept, dropped frame absent", 10 + k);
      clr();
      chk(!avail, "R5 one-cycle gap", avail, 0);
      if (k == 0) chk(!full, "R6 full clears after release", full, 0);
      if (k == 1) begin
        irq_clr = 1;  // during the gap: must be ignored
        step();
        irq_clr = 0;
      end else if (k < 5) begin
        step();
      end
    end
    step();
    chk(!avail, "R5 empty after drain", avail, 0);
    chk(ovf, "R7 overflow sticky", ovf, 1);
  endtask

  task automatic t_disable();
    mv(40); mv(41); step();
    chk(avail, "R9 pre-flush interrupt", avail, 1);
    set_en(0);
    chk(!fifo_en && !avail && !ovf, "R9 flush clears", {fifo_en, avail, ovf}, 0);
    mv(42); step();
    chk(!avail && !full && !warn, "R9 move-in ignored when off", {avail, full, warn}, 0);
    set_en(1); step();
    chk(!avail, "R9 empty after re-enable", avail, 0);
  endtask

  task automatic t_same();
    mv(20); mv(21); step();
    chk_head("R10 setup head", 20);
    put_frame(22); mv_valid = 1; irq_clr = 1;
    step();
    mv_valid = 0; irq_clr = 0;
    chk_head("R10 clear advanced head", 21);
    chk(!avail, "R10 gap", avail, 0);
    step();
    chk(avail, "R10 re-armed", avail, 1);
    clr(); step();
    chk_head("R10 concurrent move-in kept", 22);
    clr(); step();
    chk(!avail, "R10 drained", avail, 0);
    for (int i = 0; i < 6; i++) mv(30 + i);
    step();
    put_frame(36); mv_valid = 1; irq_clr = 1;
    step();
    mv_valid = 0; irq_clr = 0;
    chk(!full, "R10 full drops after release", full, 0);
    chk(ovf, "R10 move-in on full discarded", ovf, 1);
    for (int k = 1; k < 6; k++) begin
      step();
      chk_head("R10 drain order", 30 + k);
      clr();
    end
    step();
    chk(!avail, "R10 dropped frame never stored", avail, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_cfg();
    t_single();
    t_fill();
    t_disable();
    t_same();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule